// File: doc/BRIEF.md
# Multi-way branch target coprocessor

This block sits beside a host integer unit and shortens a multi-way branch to one table lookup. It holds eight entries. Entries 0 to 6 each pair a 32-bit case value with a 32-bit jump target. Entry 7 is the fallback: it holds only a target, which is used when no case value matches.

The host fills the table at run time through a single write port. Each write goes to one field of one entry. To branch, the host pulses `start_i` with a selector value. One cycle later the block returns the target address for the 32-bit data bus, together with flags that say which kind of entry produced it.

Every entry carries a valid bit. The bit is cleared by reset and set when the entry's target is written. Matching runs against all case entries in parallel. The lowest-numbered valid entry whose case value equals the selector wins. If nothing matches, the fallback entry is used. If the fallback entry itself has never been loaded, the block reports an error. All logic runs in the host's clock domain, and the path from table to output crosses one comparator bank and one priority mux.

Top module: `jump_table_cop`

## Requirements
- R1: After reset, all eight entries are invalid and `done_o`, `addr_o`, `hit_o` and `err_o` are 0. A lookup issued before any load reports the error result.
- R2: A write with `wr_en_i`=1 updates one field of entry `wr_idx_i` at the clock edge. `wr_fld_i`=0 writes the case value and `wr_fld_i`=1 writes the target and sets the entry valid. One write per cycle, so a full cold load of 8 targets followed by a lookup yields its result within 10 cycles.
- R3: A `start_i` sampled at edge N produces `done_o`=1 for exactly the cycle after edge N, with results valid in that same cycle. Back-to-back starts give back-to-back done pulses.
- R4: A selector equal to the case value of a valid entry among 0..6 returns that entry's target with `hit_o`=1 and `err_o`=0.
- R5: When several valid case entries match, the lowest entry index wins.
- R6: When no case entry matches and entry 7 is valid, the result is entry 7's target with `hit_o`=0 and `err_o`=0.
- R7: When no case entry matches and entry 7 is invalid, the result is `addr_o`=0, `hit_o`=0 and `err_o`=1.
- R8: An entry whose case value was written but whose target was never written does not match.
- R9: A write in the same cycle as a `start_i` affects only later lookups. The concurrent lookup sees the old table contents.
- R10: `addr_o`, `hit_o` and `err_o` hold their values until the next lookup completes.
- R11: A case-value write to entry 7 has no effect, and entry 7 never matches a selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the host |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 3 | Entry index of the write (7 = fallback) |
| wr_fld_i | input | 1 | Field of the write: 0 case value, 1 target |
| wr_data_i | input | 32 | Write data |
| start_i | input | 1 | Lookup request |
| sel_i | input | 32 | Selector value to match |
| done_o | output | 1 | One-cycle result strobe |
| addr_o | output | 32 | Selected jump target |
| hit_o | output | 1 | 1 when a case entry matched |
| err_o | output | 1 | 1 when nothing matched and the fallback is unloaded |

## Verification
The bench targets four corner cases.

- Overlapping case values: the bench loads two entries with the same case value. A design with reversed priority returns the higher entry's target.
- Half-loaded entries: the bench writes a case value without a target. A design that ignores the valid bit hits on that entry and returns a zero or stale target instead of the fallback.
- Write during a lookup: the bench writes an entry in the same cycle it looks that entry up. A design that forwards the new write returns the new target one lookup too early.
- Missing fallback and reset: the bench looks up with no fallback loaded, and resets in the middle of a run. A wrong fallback path shows up as a nonzero address with a clear error flag, or as leftover entries after reset.

// File: rtl/jtc_pkg.sv
package jtc_pkg;
  parameter int unsigned JTC_ENTRIES = 8;
  parameter int unsigned JTC_DW      = 32;

  typedef enum logic {
    FLD_CASE   = 1'b0,
    FLD_TARGET = 1'b1
  } fld_e;
endpackage

// File: rtl/jtc_regfile.sv
module jtc_regfile
  import jtc_pkg::*;
#(
  parameter int unsigned N    = JTC_ENTRIES,
  parameter int unsigned DW   = JTC_DW,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IW-1:0]        idx_i,
  input  fld_e                 fld_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [N-1:0][DW-1:0] case_o,
  output logic [N-1:0][DW-1:0] tgt_o,
  output logic [N-1:0]         valid_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic sel_w;
    assign sel_w = we_i && (idx_i == IW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tgt_o[i]   <= '0;
        valid_o[i] <= 1'b0;
      end else if (sel_w && fld_i == FLD_TARGET) begin
        tgt_o[i]   <= wdata_i;
        valid_o[i] <= 1'b1;
      end
    end

    if (i < N - 1) begin : g_case
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           case_o[i] <= '0;
        else if (sel_w && fld_i == FLD_CASE)   case_o[i] <= wdata_i;
      end
    end else begin : g_dflt
      // fallback slot keeps no case value
      assign case_o[i] = '0;
    end
  end
endmodule

// File: rtl/jtc_match.sv
module jtc_match
  import jtc_pkg::*;
#(
  parameter int unsigned N    = JTC_ENTRIES,
  parameter int unsigned DW   = JTC_DW,
  localparam int unsigned IW  = $clog2(N),
  localparam int unsigned NC  = N - 1
) (
  input  logic [DW-1:0]        sel_i,
  input  logic [N-1:0][DW-1:0] case_i,
  input  logic [N-1:0]         valid_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  logic [NC-1:0] eq;

  for (genvar i = 0; i < NC; i++) begin : g_cmp
    assign eq[i] = valid_i[i] && (case_i[i] == sel_i);
  end

  // lowest index wins: scan downward so low entries overwrite
  always_comb begin
    hit_o = 1'b0;
    idx_o = IW'(NC);
    for (int i = NC - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/jtc_select.sv
module jtc_select
  import jtc_pkg::*;
#(
  parameter int unsigned N    = JTC_ENTRIES,
  parameter int unsigned DW   = JTC_DW,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic                 hit_i,
  input  logic [IW-1:0]        idx_i,
  input  logic [N-1:0][DW-1:0] tgt_i,
  input  logic [N-1:0]         valid_i,
  output logic [DW-1:0]        addr_o,
  output logic                 err_o
);
  always_comb begin
    addr_o = '0;
    err_o  = 1'b0;
    if (hit_i)                addr_o = tgt_i[idx_i];
    else if (valid_i[N-1])    addr_o = tgt_i[N-1];
    else                      err_o  = 1'b1;
  end
endmodule

// File: rtl/jump_table_cop.sv
module jump_table_cop
  import jtc_pkg::*;
#(
  parameter int unsigned N    = JTC_ENTRIES,
  parameter int unsigned DW   = JTC_DW,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_fld_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          start_i,
  input  logic [DW-1:0] sel_i,
  output logic          done_o,
  output logic [DW-1:0] addr_o,
  output logic          hit_o,
  output logic          err_o
);
  logic [N-1:0][DW-1:0] case_q, tgt_q;
  logic [N-1:0]         valid_q;
  logic                 m_hit;
  logic [IW-1:0]        m_idx;
  logic [DW-1:0]        s_addr;
  logic                 s_err;

  jtc_regfile #(.N(N), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .idx_i   (wr_idx_i),
    .fld_i   (fld_e'(wr_fld_i)),
    .wdata_i (wr_data_i),
    .case_o  (case_q),
    .tgt_o   (tgt_q),
    .valid_o (valid_q)
  );

  jtc_match #(.N(N), .DW(DW)) u_match (
    .sel_i   (sel_i),
    .case_i  (case_q),
    .valid_i (valid_q),
    .hit_o   (m_hit),
    .idx_o   (m_idx)
  );

  jtc_select #(.N(N), .DW(DW)) u_sel (
    .hit_i   (m_hit),
    .idx_i   (m_idx),
    .tgt_i   (tgt_q),
    .valid_i (valid_q),
    .addr_o  (s_addr),
    .err_o   (s_err)
  );

  // lookup reads pre-edge table state, so a concurrent write is not seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      addr_o <= '0;
      hit_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        addr_o <= s_addr;
        hit_o  <= m_hit;
        err_o  <= s_err;
      end
    end
  end
endmodule

// File: rtl/jtc_checker.sv
module jtc_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          done_o,
  input logic [DW-1:0] addr_o,
  input logic          hit_o,
  input logic          err_o
);
  p_done_after_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  p_no_stray_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  p_err_zero_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (addr_o == '0 && !hit_o));

  p_hold_results_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(addr_o) && $stable(hit_o) && $stable(err_o)));

  p_hit_excl_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !err_o);
endmodule

bind jump_table_cop jtc_checker #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .addr_o  (addr_o),
  .hit_o   (hit_o),
  .err_o   (err_o)
);

// File: tb/tb_jump_table_cop.sv
module tb_jump_table_cop;
  localparam int N  = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic          wr_fld = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          start = 1'b0;
  logic [DW-1:0] sel = '0;
  logic          done_o, hit_o, err_o;
  logic [DW-1:0] addr_o;

  always #2.5 clk = ~clk;

  jump_table_cop dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_fld_i(wr_fld), .wr_data_i(wr_data), .start_i(start), .sel_i(sel),
    .done_o(done_o), .addr_o(addr_o), .hit_o(hit_o), .err_o(err_o)
  );

  typedef struct {
    logic [DW-1:0] addr;
    logic          hit;
    logic          err;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            n_chk = 0, n_fail = 0, n_done = 0, cyc = 0;
  bit            finished = 1'b0;
  logic [DW-1:0] m_case [N];
  logic [DW-1:0] m_tgt  [N];
  logic          m_val  [N];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_case[i] = '0; m_tgt[i] = '0; m_val[i] = 1'b0;
    end
  endtask

  function automatic exp_t predict(input logic [DW-1:0] s, input string tag);
    exp_t e;
    e.tag = tag;
    for (int i = 0; i < N - 1; i++)
      if (m_val[i] && m_case[i] == s) begin
        e.addr = m_tgt[i]; e.hit = 1'b1; e.err = 1'b0;
        return e;
      end
    if (m_val[N-1]) begin
      e.addr = m_tgt[N-1]; e.hit = 1'b0; e.err = 1'b0;
    end else begin
      e.addr = '0; e.hit = 1'b0; e.err = 1'b1;
    end
    return e;
  endfunction

  task automatic model_write(input int idx, input bit fld, input logic [DW-1:0] d);
    if (fld) begin
      m_tgt[idx] = d; m_val[idx] = 1'b1;
    end else if (idx < N - 1) begin
      m_case[idx] = d;
    end
  endtask

  // all tasks start and end at posedge+1
  task automatic wr(input int idx, input bit fld, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_fld = fld; wr_data = d;
    model_write(idx, fld, d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [DW-1:0] s, input string tag);
    sb.push_back(predict(s, tag));
    start = 1'b1; sel = s;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic lookup_with_write(input logic [DW-1:0] s, input int idx,
                                   input bit fld, input logic [DW-1:0] d,
                                   input string tag);
    sb.push_back(predict(s, tag));
    model_write(idx, fld, d);
    start = 1'b1; sel = s;
    wr_en = 1'b1; wr_idx = 3'(idx); wr_fld = fld; wr_data = d;
    @(posedge clk); #1;
    start = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // monitor: compare each done pulse against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      n_done++;
      if (sb.size() == 0) begin
        check(1'b0, "R3", "done pulse with no pending lookup");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(addr_o == e.addr && hit_o == e.hit && err_o == e.err, e.tag,
              $sformatf("addr=%h hit=%0b err=%0b expected addr=%h hit=%0b err=%0b",
                        addr_o, hit_o, err_o, e.addr, e.hit, e.err));
      end
    end
  end

  initial begin
    #(5 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    int            t0;
    model_clear();
    idle(3);
    @(negedge clk);
    check(!done_o && addr_o == '0 && !hit_o && !err_o, "R1",
          $sformatf("reset outputs done=%0b addr=%h hit=%0b err=%0b expected all 0",
                    done_o, addr_o, hit_o, err_o));
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);

    // R1/R7: empty table
    lookup(32'h5, "R1");
    idle(1);

    // R8: case value without target never matches
    wr(2, 1'b0, 32'hAB);
    lookup(32'hAB, "R8");
    wr(7, 1'b1, 32'h0000_1000);
    lookup(32'hAB, "R8");
    lookup(32'h999, "R6");

    // R2/R4: load all case entries
    for (int i = 0; i < N - 1; i++) begin
      wr(i, 1'b0, 32'h100 + i * 3);
      wr(i, 1'b1, 32'h8000_0000 + i * 16);
    end
    for (int i = 0; i < N - 1; i++) lookup(32'h100 + i * 3, "R4");
    lookup(32'h101, "R6");
    idle(2);

    // R3: done lasts one cycle only
    lookup(32'h103, "R3");
    @(negedge clk);
    @(negedge clk);
    check(!done_o, "R3", $sformatf("done=%0b in second cycle, expected 0", done_o));
    @(posedge clk); #1;

    // R10: outputs hold
    held = addr_o;
    idle(4);
    @(negedge clk);
    check(addr_o == held && hit_o, "R10",
          $sformatf("addr=%h hit=%0b expected addr=%h hit=1", addr_o, hit_o, held));
    @(posedge clk); #1;

    // R5: duplicate case value, lowest index wins
    wr(5, 1'b0, 32'h103);
    lookup(32'h103, "R5");
    wr(0, 1'b0, 32'h103);
    lookup(32'h103, "R5");

    // R11: case write to fallback ignored
    wr(7, 1'b0, 32'h7777);
    lookup(32'h7777, "R11");

    // R9: write concurrent with lookup
    lookup_with_write(32'h109, 3, 1'b1, 32'hDEAD_0000, "R9");
    lookup(32'h109, "R9");
    lookup_with_write(32'h5555, 4, 1'b0, 32'h5555, "R9");
    lookup(32'h5555, "R9");
    idle(3);

    // R1: reset mid-run clears table
    rst_n = 1'b0;
    model_clear();
    idle(2);
    @(negedge clk);
    check(!done_o && addr_o == '0 && !hit_o && !err_o, "R1",
          $sformatf("after reset addr=%h hit=%0b err=%0b expected 0", addr_o, hit_o, err_o));
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);
    lookup(32'h103, "R1");
    idle(1);

    // R2: cold load of all targets then lookup within 10 cycles
    t0 = cyc;
    for (int i = 0; i < N; i++) wr(i, 1'b1, 32'h4000 + i);
    lookup(32'h0, "R2");
    @(negedge clk);
    check(done_o && (cyc - t0) <= 10, "R2",
          $sformatf("done=%0b after %0d cycles, expected done within 10", done_o, cyc - t0));
    idle(3);

    check(sb.size() == 0, "R3",
          $sformatf("%0d lookups unanswered, expected 0", sb.size()));
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule